// File: doc/BRIEF.md
# Shift-and-Store Bus Register

This block is a serial-in register with a storage stage behind it and a parallel output that can be switched off so that it can share a bus. Serial data goes in at stage 1. On every rising clock edge the data moves one stage further along the shift chain. The storage stage is a level-sensitive latch. It is open while the strobe input is high and closed while the strobe is low. The latched word reaches the parallel pins only while the output enable is high. When the output enable is low, the parallel pins float and a per-bit drive-enable vector reports that they are off.

Two serial taps let several parts be chained. The first tap is the last shift stage, so it changes on the rising edge. The second tap holds the same bit, captured again on the following falling edge. A downstream part clocked by the same rising edge therefore sees a full half period of setup, even when the clock edges are slow. The stage count is a parameter with a default of 8. Reset is synchronous and active-high.

Top module: `shsr_bus_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the shift stages and the falling-edge tap clear to 0. While `rst` is high, the storage latch is held at 0.
- R2: At each rising edge with `rst` low, stage 1 takes `ser_in` and every stage k>1 takes the value stage k-1 held before the edge.
- R3: While `strobe` is high, the storage latch follows the shift stages. After a rising edge with `strobe` high, the parallel word already shows the newly shifted values within the same cycle.
- R4: While `strobe` is low, the storage latch keeps its value across rising edges. The serial taps keep updating during this time.
- R5: While `out_en` is high, `par_drv` is all ones and `par_q` shows the storage latch. Bit 0 of `par_q` is stage 1 and the top bit is the last stage.
- R6: While `out_en` is low, `par_drv` is all zeros and every bit of `par_q` is high-impedance. The serial taps are not affected.
- R7: `ser_q_pos` equals the last shift stage. At each rising edge it therefore takes the bit that was in the stage before the last.
- R8: At each falling edge, `ser_q_neg` takes the value that `ser_q_pos` has at that moment. It holds that value through the next rising edge.
- R9: Two parts are chained by feeding `ser_q_neg` of the first into `ser_in` of the second, with a shared clock. After 16 rising edges of 8-stage parts, the first bit shifted in sits in stage 8 of the second part and the last bit sits in stage 1 of the first part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Shifts on the rising edge; the second tap captures on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | Storage latch is open while high |
| out_en | input | 1 | Parallel output drive enable, active high |
| par_q | output | STAGES | Parallel word. High-impedance while `out_en` is low |
| par_drv | output | STAGES | Per-bit drive indication for `par_q` |
| ser_q_pos | output | 1 | Serial tap updated on the rising edge |
| ser_q_neg | output | 1 | Serial tap updated on the falling edge |

## Verification
The case that needs care is a shift edge and an open strobe in the same cycle. Because the latch is transparent, the shifted word must reach the parallel pins within the cycle of that edge, and not one cycle later. The bench drives this case on purpose. It holds `strobe` high over runs of rising edges, and it also mixes in random strobe, enable and data patterns. After every edge it compares the parallel word with a bench model that applies the shift first and the latch second. A second case is the shift edge together with the falling-edge tap capture in a chained pair. The bench checks that the downstream part takes the upstream bit from one edge earlier, and that no bit is lost or repeated across the 16-bit chain.

// File: rtl/shsr_pkg.sv
package shsr_pkg;
  // Default depth of the shift chain and storage latch.
  parameter int unsigned SHSR_STAGES_DEF = 8;

  // Replicates one enable bit across the parallel word.
  function automatic logic [SHSR_STAGES_DEF-1:0] shsr_fill(input logic bit_v);
    shsr_fill = {SHSR_STAGES_DEF{bit_v}};
  endfunction
endpackage

// File: rtl/shsr_chain.sv
module shsr_chain #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] stage_q
);
  localparam int unsigned LAST = STAGES - 1;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[LAST-1:0], din};
  end

  // R2
  head_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(din));

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_step
      // R2
      step_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage_q[k] == $past(stage_q[k-1]));
    end
  endgenerate

  // R1
  clear_chk: assert property (@(posedge clk) $past(rst) |-> stage_q == '0);
endmodule

// File: rtl/shsr_latch.sv
module shsr_latch #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_en,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  // The clock feeds only the checks; the storage itself is level-sensitive.
  always_latch begin
    if (rst)          q = '0;
    else if (open_en) q = d;
  end

  // R3
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    open_en |-> q == d);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_en && !$past(open_en) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/shsr_edge_tap.sv
module shsr_edge_tap (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R8: between falling edges the tap matches what the last stage held.
  fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q == d);
endmodule

// File: rtl/shsr_bus_reg.sv
module shsr_bus_reg #(
  parameter int unsigned STAGES = shsr_pkg::SHSR_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              out_en,
  output logic [STAGES-1:0] par_q,
  output logic [STAGES-1:0] par_drv,
  output logic              ser_q_pos,
  output logic              ser_q_neg
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stages_w;
  logic [STAGES-1:0] held_w;

  shsr_chain #(.STAGES(STAGES)) chain_i (
    .clk(clk), .rst(rst), .din(ser_in), .stage_q(stages_w)
  );

  shsr_latch #(.STAGES(STAGES)) store_i (
    .clk(clk), .rst(rst), .open_en(strobe), .d(stages_w), .q(held_w)
  );

  assign ser_q_pos = stages_w[LAST];

  shsr_edge_tap tap_i (
    .clk(clk), .rst(rst), .d(ser_q_pos), .q(ser_q_neg)
  );

  assign par_drv = {STAGES{out_en}};

  generate
    for (genvar b = 0; b < STAGES; b++) begin : g_pin
      assign par_q[b] = par_drv[b] ? held_w[b] : 1'bz;
    end
  endgenerate

  // R5
  drive_all_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |-> par_drv == {STAGES{1'b1}});

  // R6
  drive_none_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> par_drv == '0);

  // R7
  pos_tap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ser_q_pos == $past(stages_w[LAST-1]));
endmodule

// File: tb/shsr_bus_reg_tb.sv
`timescale 1ns/100ps
module shsr_bus_reg_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic strobe = 1'b0;
  logic out_en = 1'b0;

  wire [N-1:0] pq_a, pq_b, drv_a, drv_b;
  wire pos_a, pos_b, neg_a, neg_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of both parts.
  logic [N-1:0] m_ch_a, m_ch_b, m_st_a, m_st_b;
  logic m_neg_a, m_neg_b;

  always #2.5 clk = ~clk;

  shsr_bus_reg #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
    .par_q(pq_a), .par_drv(drv_a), .ser_q_pos(pos_a), .ser_q_neg(neg_a)
  );

  shsr_bus_reg #(.STAGES(N)) dut_b_i (
    .clk(clk), .rst(rst), .ser_in(neg_a), .strobe(strobe), .out_en(out_en),
    .par_q(pq_b), .par_drv(drv_b), .ser_q_pos(pos_b), .ser_q_neg(neg_b)
  );

  function automatic logic [N-1:0] exp_bus(input logic oe, input logic [N-1:0] st);
    exp_bus = oe ? st : {N{1'bz}};
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string rq;
    rq = out_en ? "R5" : "R6";
    chk_vec(rq, pq_a, exp_bus(out_en, m_st_a));
    chk_vec(rq, pq_b, exp_bus(out_en, m_st_b));
    chk_vec(rq, drv_a, {N{out_en}});
    chk_bit("R7", pos_a, m_ch_a[N-1]);
    chk_bit("R7", pos_b, m_ch_b[N-1]);
    chk_bit("R8", neg_a, m_neg_a);
    chk_bit("R8", neg_b, m_neg_b);
  endtask

  // Drive inputs just after a falling edge; an open strobe passes the stages at once.
  task automatic drive(input logic d, input logic s, input logic oe);
    ser_in = d;
    strobe = s;
    out_en = oe;
    if (s) begin
      m_st_a = m_ch_a;
      m_st_b = m_ch_b;
    end
  endtask

  // One full clock: rising edge, check, falling edge, check.
  task automatic cycle();
    @(posedge clk);
    m_ch_b = {m_ch_b[N-2:0], m_neg_a};
    m_ch_a = {m_ch_a[N-2:0], ser_in};
    if (strobe) begin
      m_st_a = m_ch_a;
      m_st_b = m_ch_b;
    end
    #1;
    check_all();
    @(negedge clk);
    m_neg_a = m_ch_a[N-1];
    m_neg_b = m_ch_b[N-1];
    #1;
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] word;
    logic [N-1:0] snap_a;
    void'($urandom(32'h5eed_0417));
    m_ch_a = '0; m_ch_b = '0; m_st_a = '0; m_st_b = '0;
    m_neg_a = 1'b0; m_neg_b = 1'b0;

    // R1: reset state, storage open and bus driven.
    rst = 1'b1; strobe = 1'b1; out_en = 1'b1; ser_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk_vec("R1", pq_a, '0);
    chk_bit("R1", pos_a, 1'b0);
    chk_bit("R1", neg_a, 1'b0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b1);

    // R9: 16 bits through the chained pair, then open strobe.
    word = 16'hB38D;
    for (int i = 0; i < 16; i++) begin
      drive(word[15-i], 1'b0, 1'b1);
      cycle();
    end
    drive(1'b0, 1'b1, 1'b1);
    #0;
    for (int i = 0; i < 8; i++) begin
      chk_bit("R9", pq_b[N-1-i], word[15-i]);
      chk_bit("R9", pq_a[N-1-i], word[7-i]);
    end

    // R3: strobe held high over edges; bus follows in the edge's own cycle.
    for (int i = 0; i < 6; i++) begin
      drive(i[0], 1'b1, 1'b1);
      cycle();
      chk_bit("R3", pq_a[0], i[0]);
      chk_bit("R2", pos_a, m_ch_a[N-1]);
    end

    // R4: strobe low, bus frozen while serial taps move.
    drive(1'b1, 1'b0, 1'b1);
    snap_a = pq_a;
    for (int i = 0; i < 5; i++) begin
      drive(~i[0], 1'b0, 1'b1);
      cycle();
      chk_vec("R4", pq_a, snap_a);
    end

    // R6: bus off, serial path still shifting, then bus back on.
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, i[1], 1'b0);
      cycle();
      chk_vec("R6", drv_b, '0);
    end
    drive(1'b0, 1'b0, 1'b1);
    #0;
    chk_vec("R5", pq_a, m_st_a);

    // Random mix of data, strobe and enable.
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom), ($urandom % 3) == 0, ($urandom % 4) != 0);
      cycle();
    end

    // R1: reset mid-run clears everything again.
    drive(1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    chk_vec("R1", pq_a, '0);
    chk_vec("R1", pq_b, '0);
    chk_bit("R1", neg_a, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule